// File: doc/BRIEF.md
# Compressed Round-Constant Lane Mixer

This block holds the 24 round constants of the Keccak-f[1600] permutation. Each constant is kept as a 7-bit code rather than a full 64-bit word. It applies the selected constant to the single lane that the iota step modifies. A full constant can only have bits set at lane positions 2^g - 1 for g = 0..6, so the block needs just seven XOR taps on the lane. The other 57 bits pass straight through. The lane datapath is purely combinational from index and lane to result.

The round index comes from one of two places. In direct mode the caller supplies it on a 5-bit port. In sequencing mode an internal counter supplies it. A start pulse loads the counter with round 0. Each advance strobe then moves it on by one. The advance taken at round 23 ends the run and raises a one-cycle done pulse. A surrounding permutation datapath uses the direct mode when it tracks rounds itself, and the sequencing mode when it wants the round schedule supplied.

Top module: `rc_iota`

## Requirements
- R1: For round index i in 0..23, lane_out equals lane_in XOR the 64-bit Keccak round constant of round i. The 7-bit code bit g drives an XOR onto lane bit 2^g - 1, that is, bits 0, 1, 3, 7, 15, 31 and 63.
- R2: Lane bits other than 0, 1, 3, 7, 15, 31 and 63 always equal the corresponding bits of lane_in.
- R3: With lane_in all zero, rounds 0, 1 and 7 give 0x0000000000000001, 0x0000000000008082 and 0x8000000000008009.
- R4: An effective round index of 24 to 31 applies an all-zero code, so lane_out equals lane_in.
- R5: When use_seq is 1, the effective index is seq_idx and rnd_idx has no effect. A start pulse makes seq_idx 0 and busy 1 on the next cycle.
- R6: While busy and not starting, adv high at a clock edge moves seq_idx up by one. adv low at a clock edge leaves seq_idx unchanged.
- R7: adv taken while busy at seq_idx 23 gives done = 1, busy = 0 and seq_idx = 0 on the next cycle. done is high for exactly one cycle.
- R8: After reset, busy, done and seq_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_seq | input | 1 | 1 selects the internal counter as round index, 0 selects rnd_idx |
| rnd_idx | input | 5 | Round index in direct mode |
| lane_in | input | 64 | Incoming lane A[0,0] |
| start | input | 1 | Loads the counter with round 0 and starts a run |
| adv | input | 1 | Advance strobe for the counter |
| lane_out | output | 64 | Lane after the round constant is applied |
| seq_idx | output | 5 | Current counter round |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last round |

## Verification
The bench derives every full constant from the 8-bit LFSR that defines Keccak round constants. It then compares all 24 rounds against that, so a wrong code bit or a tap on the wrong lane position gives a mismatch on a specific round. Rounds 5/22 and 6/20 share codes, and round 23 has four taps. A table shifted by one entry or built from a faulty listing is caught there. Indices 24 to 31 must pass the lane untouched, which exposes a decoder that aliases out-of-range values onto real rounds. The sequencer is stepped with gaps in adv and with rnd_idx driven to unrelated values. It is then run through round 23, which would show a counter that skips, ignores the hold, leaks the direct index, or fails to wrap and pulse done.

// File: rtl/rc_iota.sv
module rc_iota #(
  parameter int LANE_W = 64,
  parameter int ROUNDS = 24,
  parameter int IDX_W  = 5,
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_seq,
  input  logic [IDX_W-1:0]  rnd_idx,
  input  logic [LANE_W-1:0] lane_in,
  input  logic              start,
  input  logic              adv,
  output logic [LANE_W-1:0] lane_out,
  output logic [IDX_W-1:0]  seq_idx,
  output logic              busy,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  function automatic logic [CODE_W-1:0] code_of(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:  code_of = 7'h01;
      5'd1:  code_of = 7'h1A;
      5'd2:  code_of = 7'h5E;
      5'd3:  code_of = 7'h70;
      5'd4:  code_of = 7'h1F;
      5'd5:  code_of = 7'h21;
      5'd6:  code_of = 7'h79;
      5'd7:  code_of = 7'h55;
      5'd8:  code_of = 7'h0E;
      5'd9:  code_of = 7'h0C;
      5'd10: code_of = 7'h35;
      5'd11: code_of = 7'h26;
      5'd12: code_of = 7'h3F;
      5'd13: code_of = 7'h4F;
      5'd14: code_of = 7'h5D;
      5'd15: code_of = 7'h53;
      5'd16: code_of = 7'h52;
      5'd17: code_of = 7'h48;
      5'd18: code_of = 7'h16;
      5'd19: code_of = 7'h66;
      5'd20: code_of = 7'h79;
      5'd21: code_of = 7'h58;
      5'd22: code_of = 7'h21;
      5'd23: code_of = 7'h74;
      default: code_of = '0;
    endcase
  endfunction

  function automatic int tap_of(input int b);
    tap_of = -1;
    for (int g = 0; g < CODE_W; g++)
      if (b == (1 << g) - 1) tap_of = g;
  endfunction

  logic [IDX_W-1:0]  eff_idx;
  logic [CODE_W-1:0] code;

  assign eff_idx = use_seq ? seq_idx : rnd_idx;
  assign code    = code_of(eff_idx);

  for (genvar b = 0; b < LANE_W; b++) begin : g_lane
    if (tap_of(b) >= 0) begin : g_tap
      assign lane_out[b] = lane_in[b] ^ code[tap_of(b)];
    end else begin : g_thru
      assign lane_out[b] = lane_in[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_idx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        seq_idx <= '0;
        busy    <= 1'b1;
      end else if (busy && adv) begin
        if (seq_idx == LAST) begin
          seq_idx <= '0;
          busy    <= 1'b0;
          done    <= 1'b1;
        end else begin
          seq_idx <= seq_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rc_iota_chk.sv
module rc_iota_chk #(
  parameter int LANE_W = 64,
  parameter int ROUNDS = 24,
  parameter int IDX_W  = 5,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              use_seq,
  input logic [IDX_W-1:0]  rnd_idx,
  input logic [LANE_W-1:0] lane_in,
  input logic              start,
  input logic              adv,
  input logic [LANE_W-1:0] lane_out,
  input logic [IDX_W-1:0]  seq_idx,
  input logic              busy,
  input logic              done
);

  function automatic logic [LANE_W-1:0] keep_mask();
    logic [LANE_W-1:0] m;
    m = '1;
    for (int g = 0; g < CODE_W; g++) m[(1 << g) - 1] = 1'b0;
    return m;
  endfunction

  localparam logic [LANE_W-1:0] KEEP = keep_mask();
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(ROUNDS - 1);

  logic [IDX_W-1:0] sel;
  assign sel = use_seq ? seq_idx : rnd_idx;

  AST_UNTOUCHED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out & KEEP) == (lane_in & KEEP)); // R2

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= ROUNDS) |-> lane_out == lane_in); // R4

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && seq_idx == '0); // R5

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adv && !start && seq_idx != LAST) |=> seq_idx == $past(seq_idx) + 1'b1); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv && !start) |=> $stable(seq_idx)); // R6

  AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adv && !start && seq_idx == LAST) |=> done && !busy); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

endmodule

bind rc_iota rc_iota_chk #(
  .LANE_W(LANE_W), .ROUNDS(ROUNDS), .IDX_W(IDX_W), .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/sim_rc_iota.sv
`timescale 1ns/1ps
module sim_rc_iota;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        use_seq = 1'b0;
  logic [4:0]  rnd_idx = '0;
  logic [63:0] lane_in = '0;
  logic        start = 1'b0;
  logic        adv = 1'b0;
  logic [63:0] lane_out;
  logic [4:0]  seq_idx;
  logic        busy;
  logic        done;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  rc_iota u0 (.*);

  function automatic bit lfsr_bit(int t);
    logic [8:0] r = 9'h001;
    for (int k = 0; k < t % 255; k++) begin
      r = r << 1;
      if (r[8]) r = r ^ 9'h171;
    end
    return r[0];
  endfunction

  function automatic logic [63:0] full_rc(int i);
    logic [63:0] c = '0;
    for (int j = 0; j < 7; j++) c[(1 << j) - 1] = lfsr_bit(j + 7 * i);
    return c;
  endfunction

  function automatic logic [63:0] pat(int i);
    return 64'hC3A5_96F0_1E2D_3B4C ^ (64'h9E37_79B9_7F4A_7C15 * (i + 1));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_direct(int idx, logic [63:0] l, logic [63:0] e, string req);
    @(posedge clk); #1;
    use_seq = 1'b0;
    rnd_idx = idx[4:0];
    lane_in = l;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic step_seq();
    adv = 1'b1;
    @(posedge clk); #1;
    adv = 1'b0;
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, lane_out, e);
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 busy", 64'(busy), 64'd0);
    check("R8 done", 64'(done), 64'd0);
    check("R8 seq_idx", 64'(seq_idx), 64'd0);
    rst_n = 1'b1;

    drive_direct(0, '0, 64'h0000_0000_0000_0001, "R3 round0");
    drive_direct(1, '0, 64'h0000_0000_0000_8082, "R3 round1");
    drive_direct(7, '0, 64'h8000_0000_0000_8009, "R3 round7");

    for (int i = 0; i < 24; i++) begin
      drive_direct(i, pat(i), pat(i) ^ full_rc(i), "R1 round vs lfsr");
      drive_direct(i, '1, ~full_rc(i), "R2 all-ones lane");
    end

    for (int i = 24; i < 32; i++)
      drive_direct(i, pat(i), pat(i), "R4 out of range");

    @(posedge clk); #1;
    use_seq = 1'b1;
    rnd_idx = 5'd9;
    lane_in = pat(40);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R5 start busy", 64'(busy), 64'd1);
    check("R5 start idx", 64'(seq_idx), 64'd0);
    exp_q.push_back(pat(40) ^ full_rc(0));
    tag_q.push_back("R5 rnd_idx ignored");

    for (int k = 1; k < 24; k++) begin
      step_seq();
      check("R6 advance", 64'(seq_idx), 64'(k));
      rnd_idx = 5'(31 - k);
      exp_q.push_back(pat(40) ^ full_rc(k));
      tag_q.push_back("R5 seq lane");
      if (k % 5 == 0) begin
        @(posedge clk); #1;
        check("R6 hold", 64'(seq_idx), 64'(k));
      end
    end

    step_seq();
    check("R7 done", 64'(done), 64'd1);
    check("R7 busy low", 64'(busy), 64'd0);
    check("R7 idx wrap", 64'(seq_idx), 64'd0);
    @(posedge clk); #1;
    check("R7 done pulse", 64'(done), 64'd0);
    step_seq();
    check("R6 idle no step", 64'(seq_idx), 64'd0);

    @(posedge clk); #1;
    finish_run();
  end
endmodule